// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Critical-Word-First Refill

This block is a synchronous, read-only instruction cache with direct-mapped placement. The core presents a 32-bit byte address on a valid/ready request channel. On a hit the instruction word comes back one cycle after acceptance. On a miss the line is refilled from memory, starting with the word the core asked for. That word is passed straight to the core as soon as it returns, so the core restarts early while the rest of the line is still streaming in.

Each word of a line has its own presence bit. While a refill runs, the core may keep fetching: any request that hits is served, including a request for a word of the line under refill that has already landed. A request that misses during a refill is held off until the refill ends. The memory side issues single-word reads, each carrying a word offset and the line-frame address. Only one read is outstanding at a time, and the memory may take any number of cycles (at least one) to answer.

Back-pressure rules for the request channel: a request transfers on a clock edge where `req_valid` and `req_ready` are both high, and the core keeps `req_addr` stable while it waits. The response channel has no back-pressure: `rsp_valid` is a one-cycle strobe that the core must take. The memory read channel has no ready: `mem_req_valid` is a one-cycle strobe, and `mem_rsp_valid` must come only for the single outstanding read.

Top module: `icache_cwf`

## Requirements
- R1: The request address is split as word offset = bits [4:2], line index = bits [12:5] and tag = bits [31:13]. Two addresses with the same index and different tags share one frame, so filling one evicts the other.
- R2: A request hits when the frame's valid bit is set, the stored tag equals the address tag and the word's presence bit is set. A hit is accepted when the block can take requests, and `rsp_valid` with the stored word follows in the next cycle, with no memory read.
- R3: A miss accepted while no refill runs starts a refill. The first read is issued in the cycle after acceptance, with `mem_req_off` = the missed offset and `mem_req_frame` = address bits [31:5]. Every read of that refill carries the same frame address.
- R4: A refill reads exactly 8 words in the order off, off+1, ... wrapping modulo 8, with at most one read outstanding. Each next read is issued in the cycle after the previous word returns.
- R5: The first returned word of a refill appears on `rsp_valid`/`rsp_data` in the cycle after its `mem_rsp_valid`, before the refill completes.
- R6: During a refill, a request for a word of the line under refill that has already arrived is served with no wait for refill completion.
- R7: `req_ready` stays low while the critical word is awaited. A request that misses during a refill is held with `req_ready` low and is accepted in the cycle `fill_done` is high.
- R8: `fill_done` pulses high for exactly one cycle per refill, in the cycle after the eighth word returns.
- R9: Synchronous active-high `rst` clears all valid bits, so previously filled addresses miss afterwards. After reset `req_ready` is high and `rsp_valid`, `mem_req_valid` and `fill_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core fetch request valid |
| req_ready | output | 1 | Cache can accept the request |
| req_addr | input | 32 | Fetch byte address |
| rsp_valid | output | 1 | Instruction word valid (one-cycle strobe) |
| rsp_data | output | 32 | Instruction word |
| mem_req_valid | output | 1 | Memory word read strobe |
| mem_req_off | output | 3 | Word offset within the line |
| mem_req_frame | output | 27 | Line-frame address (address bits [31:5]) |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 32 | Memory read data |
| fill_done | output | 1 | One-cycle pulse at refill completion |

## Verification
Misses are tried at word offsets 0, 5 and 7, with memory latencies of 1, 3, 5 and 6 cycles. Offset 0 shows a plain ascending order, while 5 and 7 show whether the wrap is modulo 8 and whether the critical word really comes first. Hits issued during a refill, to words already present and to a word still in flight, tell early restart apart from waiting for the whole line. A miss to another line during a refill must show the stall ending exactly at `fill_done`. A same-index/different-tag pair and a mid-run reset separate a correct tag and valid update from stale hits.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_CRIT = 2'd1,
    FS_FILL = 2'd2
  } fill_state_e;
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
  parameter int LINES = 256,
  parameter int TAG_W = 19,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/icache_line_store.sv
module icache_line_store #(
  parameter int LINES  = 256,
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_present,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [WORD_W-1:0] wr_data
);
  logic [WORD_W-1:0] word_q [LINES*WORDS];
  logic [LINES-1:0][WORDS-1:0] pres_all;

  always_ff @(posedge clk) begin
    if (wr_en) word_q[{wr_idx, wr_off}] <= wr_data;
  end

  // one presence vector per frame
  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [WORDS-1:0] bits_q;
    always_ff @(posedge clk) begin
      if (rst) bits_q <= '0;
      else if (clr_en && clr_idx == IDX_W'(l)) bits_q <= '0;
      else if (wr_en && wr_idx == IDX_W'(l)) bits_q[wr_off] <= 1'b1;
    end
    assign pres_all[l] = bits_q;
  end

  assign rd_data    = word_q[{rd_idx, rd_off}];
  assign rd_present = pres_all[rd_idx][rd_off];
endmodule

// File: rtl/icache_fill_ctrl.sv
module icache_fill_ctrl
  import icache_pkg::*;
#(
  parameter int OFF_W   = 3,
  parameter int FRAME_W = 27,
  parameter int IDX_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [OFF_W-1:0]   start_off,
  input  logic [FRAME_W-1:0] start_frame,
  input  logic               mem_rsp_valid,
  output fill_state_e        state,
  output logic               mem_req_valid,
  output logic [OFF_W-1:0]   mem_req_off,
  output logic [FRAME_W-1:0] mem_req_frame,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [OFF_W-1:0]   wr_off,
  output logic               crit_valid,
  output logic               fill_done
);
  fill_state_e        state_q;
  logic [OFF_W-1:0]   off_q;
  logic [OFF_W-1:0]   beat_q;
  logic [FRAME_W-1:0] frame_q;
  logic               req_q;
  logic               done_q;
  logic               beat_in;

  assign beat_in = mem_rsp_valid && (state_q != FS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FS_IDLE;
      off_q   <= '0;
      beat_q  <= '0;
      frame_q <= '0;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      if (state_q == FS_IDLE) begin
        if (start) begin
          state_q <= FS_CRIT;
          off_q   <= start_off;
          frame_q <= start_frame;
          beat_q  <= '0;
          req_q   <= 1'b1;
        end
      end else if (beat_in) begin
        beat_q <= beat_q + 1'b1;
        if (beat_q == '1) begin
          state_q <= FS_IDLE;
          done_q  <= 1'b1;
        end else begin
          state_q <= FS_FILL;
          off_q   <= off_q + 1'b1;  // wraps within the line
          req_q   <= 1'b1;
        end
      end
    end
  end

  assign state         = state_q;
  assign mem_req_valid = req_q;
  assign mem_req_off   = off_q;
  assign mem_req_frame = frame_q;
  assign wr_en         = beat_in;
  assign wr_idx        = frame_q[IDX_W-1:0];
  assign wr_off        = off_q;
  assign crit_valid    = beat_in && (state_q == FS_CRIT);
  assign fill_done     = done_q;
endmodule

// File: rtl/icache_cwf.sv
module icache_cwf
  import icache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int LINES  = 256,
  parameter int WORDS  = 8,
  localparam int BYTE_W  = $clog2(WORD_W / 8),
  localparam int OFF_W   = $clog2(WORDS),
  localparam int IDX_W   = $clog2(LINES),
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W - BYTE_W,
  localparam int FRAME_W = ADDR_W - OFF_W - BYTE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  output logic [WORD_W-1:0]  rsp_data,
  output logic               mem_req_valid,
  output logic [OFF_W-1:0]   mem_req_off,
  output logic [FRAME_W-1:0] mem_req_frame,
  input  logic               mem_rsp_valid,
  input  logic [WORD_W-1:0]  mem_rsp_data,
  output logic               fill_done
);
  logic [OFF_W-1:0]   a_off;
  logic [IDX_W-1:0]   a_idx;
  logic [TAG_W-1:0]   a_tag;
  logic [FRAME_W-1:0] a_frame;
  logic               unused_byte;

  assign a_off       = req_addr[BYTE_W +: OFF_W];
  assign a_idx       = req_addr[BYTE_W+OFF_W +: IDX_W];
  assign a_tag       = req_addr[ADDR_W-1 -: TAG_W];
  assign a_frame     = req_addr[ADDR_W-1 -: FRAME_W];
  assign unused_byte = ^req_addr[BYTE_W-1:0];

  logic               t_valid;
  logic [TAG_W-1:0]   t_tag;
  logic [WORD_W-1:0]  w_data;
  logic               w_present;
  logic               hit, accept, start;
  fill_state_e        fstate;
  logic               wr_en, crit_valid;
  logic [IDX_W-1:0]   wr_idx;
  logic [OFF_W-1:0]   wr_off;

  assign hit       = t_valid && (t_tag == a_tag) && w_present;
  assign req_ready = (fstate == FS_IDLE) || ((fstate == FS_FILL) && hit);
  assign accept    = req_valid && req_ready;
  assign start     = accept && !hit;

  icache_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst),
    .rd_idx(a_idx), .rd_valid(t_valid), .rd_tag(t_tag),
    .wr_en(start), .wr_idx(a_idx), .wr_tag(a_tag)
  );

  icache_line_store #(.LINES(LINES), .WORDS(WORDS), .WORD_W(WORD_W)) u_lines (
    .clk(clk), .rst(rst),
    .rd_idx(a_idx), .rd_off(a_off), .rd_data(w_data), .rd_present(w_present),
    .clr_en(start), .clr_idx(a_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_off(wr_off), .wr_data(mem_rsp_data)
  );

  icache_fill_ctrl #(.OFF_W(OFF_W), .FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_fill (
    .clk(clk), .rst(rst),
    .start(start), .start_off(a_off), .start_frame(a_frame),
    .mem_rsp_valid(mem_rsp_valid), .state(fstate),
    .mem_req_valid(mem_req_valid), .mem_req_off(mem_req_off),
    .mem_req_frame(mem_req_frame),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_off(wr_off),
    .crit_valid(crit_valid), .fill_done(fill_done)
  );

  // response register: a hit and the critical word never coincide
  logic              rsp_v_q;
  logic [WORD_W-1:0] rsp_d_q;

  always_ff @(posedge clk) begin
    if (rst) rsp_v_q <= 1'b0;
    else     rsp_v_q <= (accept && hit) || crit_valid;
  end

  always_ff @(posedge clk) begin
    if (accept && hit) rsp_d_q <= w_data;
    else if (crit_valid) rsp_d_q <= mem_rsp_data;
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_data  = rsp_d_q;
endmodule

// File: rtl/icache_cwf_chk.sv
module icache_cwf_chk #(
  parameter int WORD_W = 32,
  parameter int OFF_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [WORD_W-1:0] rsp_data,
  input logic              mem_req_valid,
  input logic [OFF_W-1:0]  mem_req_off,
  input logic              mem_rsp_valid,
  input logic [WORD_W-1:0] mem_rsp_data,
  input logic              fill_done
);
  logic             out_q;
  logic [OFF_W-1:0] beat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= 1'b0;
      beat_q <= '0;
    end else begin
      if (mem_req_valid) out_q <= 1'b1;
      else if (mem_rsp_valid) out_q <= 1'b0;
      if (mem_rsp_valid && out_q) beat_q <= beat_q + 1'b1;
    end
  end

  assert_one_outstanding_R4: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !out_q);

  assert_offset_step_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && $past(mem_rsp_valid)) |-> (mem_req_off == OFF_W'($past(mem_req_off) + 1'b1)));

  assert_accept_answered_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (rsp_valid || mem_req_valid));

  assert_early_restart_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_rsp_valid && out_q && beat_q == '0) |=> (rsp_valid && rsp_data == $past(mem_rsp_data)));

  assert_crit_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (out_q && beat_q == '0) |-> !req_ready);

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_rsp_valid && out_q && beat_q == '1) |=> fill_done);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    fill_done |=> !fill_done);

  assert_reset_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (req_ready && !rsp_valid && !mem_req_valid && !fill_done));
endmodule

bind icache_cwf icache_cwf_chk #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/icache_cwf_bench.sv
`timescale 1ns/1ps
module icache_cwf_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        mem_req_valid;
  logic [2:0]  mem_req_off;
  logic [26:0] mem_req_frame;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        fill_done;

  icache_cwf u_icache_cwf (.*);

  always #10 clk = ~clk;  // 50 MHz

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  int mem_lat = 3;
  int log_n = 0;
  logic [2:0]  off_log [64];
  logic [26:0] fr_log  [64];
  int done_cnt = 0, done_cyc = 0;
  int proto_err = 0;
  bit pend = 1'b0;
  int cnt = 0;
  logic [2:0]  p_off;
  logic [26:0] p_fr;

  function automatic logic [31:0] mdata(input logic [26:0] fr, input logic [2:0] o);
    return {fr, o, 2'b00} ^ 32'h5A5A_C3C3;
  endfunction

  function automatic logic [31:0] mk(input logic [18:0] t, input logic [7:0] i, input logic [2:0] o);
    return {t, i, o, 2'b00};
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (!rst && fill_done) begin
    done_cnt = done_cnt + 1;
    done_cyc = cyc;
  end

  // memory model, one read at a time, latency mem_lat
  always @(negedge clk) begin
    if (rst) begin
      mem_rsp_valid <= 1'b0;
      pend = 1'b0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid) begin
        if (pend) proto_err = proto_err + 1;
        pend = 1'b1;
        cnt = mem_lat;
        p_off = mem_req_off;
        p_fr = mem_req_frame;
        if (log_n < 64) begin
          off_log[log_n] = mem_req_off;
          fr_log[log_n]  = mem_req_frame;
        end
        log_n = log_n + 1;
      end else if (pend) begin
        cnt = cnt - 1;
        if (cnt == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mdata(p_fr, p_off);
          pend = 1'b0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic core_req(input logic [31:0] a, output logic [31:0] d, output int acc_cyc, output int rlat);
    bit r;
    int n;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = a;
    forever begin
      #1;
      r = req_ready;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    @(negedge clk);
    acc_cyc = cyc;
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 300) begin
      @(negedge clk);
      n++;
    end
    rlat = n;
    d = rsp_data;
  endtask

  task automatic wait_done(input int target);
    int n = 0;
    while (done_cnt < target && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R9 ready after reset", 32'(req_ready), 32'd1);
    chk(!rsp_valid && !mem_req_valid && !fill_done, "R9 outputs idle after reset",
        {29'd0, rsp_valid, mem_req_valid, fill_done}, 32'd0);
  endtask

  task automatic t_miss_wrap(input logic [31:0] a, input int lat);
    logic [31:0] d;
    int ac, rl, d0;
    bit ord_ok, fr_ok;
    mem_lat = lat;
    log_n = 0;
    d0 = done_cnt;
    core_req(a, d, ac, rl);
    chk(d == mdata(a[31:5], a[4:2]), "R5 critical word data", d, mdata(a[31:5], a[4:2]));
    chk(done_cnt == d0, "R5 critical word before fill end", 32'(done_cnt), 32'(d0));
    wait_done(d0 + 1);
    repeat (3) @(negedge clk);
    chk(log_n == 8, "R4 eight reads per fill", 32'(log_n), 32'd8);
    ord_ok = 1'b1;
    fr_ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (off_log[i] != 3'(a[4:2] + 3'(i))) ord_ok = 1'b0;
      if (fr_log[i] != a[31:5]) fr_ok = 1'b0;
    end
    chk(ord_ok, "R4 wrap order", {29'd0, off_log[1]}, {29'd0, 3'(a[4:2] + 3'd1)});
    chk(fr_ok, "R3 frame address on reads", {5'd0, fr_log[0]}, {5'd0, a[31:5]});
    chk(done_cnt == d0 + 1, "R8 one fill_done pulse", 32'(done_cnt), 32'(d0 + 1));
    for (int i = 0; i < 8; i++) begin
      logic [31:0] ai;
      ai = {a[31:5], 3'(i), 2'b00};
      core_req(ai, d, ac, rl);
      chk(d == mdata(a[31:5], 3'(i)) && rl == 0, "R2 hit data and latency", d, mdata(a[31:5], 3'(i)));
    end
    chk(log_n == 8, "R2 hits issue no read", 32'(log_n), 32'd8);
  endtask

  task automatic t_restart(input logic [31:0] a, input int lat);
    logic [31:0] d;
    int ac, rl, d0;
    mem_lat = lat;
    log_n = 0;
    d0 = done_cnt;
    core_req(a, d, ac, rl);
    chk(d == mdata(a[31:5], a[4:2]), "R5 restart critical data", d, mdata(a[31:5], a[4:2]));
    core_req({a[31:5], 3'(a[4:2] + 3'd1), 2'b00}, d, ac, rl);
    chk(d == mdata(a[31:5], 3'(a[4:2] + 3'd1)), "R6 next word during fill", d, mdata(a[31:5], 3'(a[4:2] + 3'd1)));
    chk(done_cnt == d0, "R6 served before fill end", 32'(done_cnt), 32'(d0));
    core_req(a, d, ac, rl);
    chk(rl == 0 && done_cnt == d0, "R6 present word hits during fill", 32'(rl), 32'd0);
    wait_done(d0 + 1);
  endtask

  task automatic t_stall(input logic [31:0] a, input logic [31:0] b, input int lat);
    logic [31:0] d;
    int ac, rl, d0;
    mem_lat = lat;
    d0 = done_cnt;
    core_req(a, d, ac, rl);
    core_req(b, d, ac, rl);
    chk(done_cnt >= d0 + 1, "R7 miss waits for fill end", 32'(done_cnt), 32'(d0 + 1));
    chk(ac == done_cyc + 1, "R7 stalled miss accepted in fill_done cycle", 32'(ac), 32'(done_cyc + 1));
    chk(d == mdata(b[31:5], b[4:2]), "R7 stalled miss data", d, mdata(b[31:5], b[4:2]));
    wait_done(d0 + 2);
  endtask

  task automatic t_evict(input logic [31:0] x, input logic [31:0] y);
    logic [31:0] d;
    int ac, rl, d0;
    mem_lat = 2;
    log_n = 0;
    d0 = done_cnt;
    core_req(y, d, ac, rl);
    chk(log_n > 0 && fr_log[0] == y[31:5], "R1 same index other tag misses", {5'd0, fr_log[0]}, {5'd0, y[31:5]});
    chk(d == mdata(y[31:5], y[4:2]), "R1 conflicting line data", d, mdata(y[31:5], y[4:2]));
    wait_done(d0 + 1);
    log_n = 0;
    core_req(x, d, ac, rl);
    chk(log_n > 0, "R1 evicted line misses", 32'(log_n), 32'd1);
    chk(d == mdata(x[31:5], x[4:2]), "R1 refetched data", d, mdata(x[31:5], x[4:2]));
    wait_done(d0 + 2);
  endtask

  task automatic t_reset_clears(input logic [31:0] a);
    logic [31:0] d;
    int ac, rl, d0;
    mem_lat = 1;
    log_n = 0;
    core_req(a, d, ac, rl);
    chk(log_n == 0 && rl == 0, "R9 line cached before reset", 32'(log_n), 32'd0);
    do_reset();
    log_n = 0;
    d0 = done_cnt;
    core_req(a, d, ac, rl);
    chk(log_n > 0, "R9 reset clears valid", 32'(log_n), 32'd1);
    chk(d == mdata(a[31:5], a[4:2]), "R9 data after reset", d, mdata(a[31:5], a[4:2]));
    wait_done(d0 + 1);
  endtask

  initial begin
    #(20 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    t_reset_state();
    t_miss_wrap(mk(19'h0ABCD, 8'h12, 3'd5), 3);
    t_miss_wrap(mk(19'h00001, 8'h40, 3'd0), 1);
    t_miss_wrap(mk(19'h7FFFF, 8'hFF, 3'd7), 5);
    t_restart(mk(19'h01234, 8'h33, 3'd2), 6);
    t_stall(mk(19'h02222, 8'h50, 3'd4), mk(19'h03333, 8'h51, 3'd1), 4);
    t_evict(mk(19'h0ABCD, 8'h12, 3'd5), mk(19'h05555, 8'h12, 3'd3));
    t_reset_clears(mk(19'h7FFFF, 8'hFF, 3'd7));
    chk(proto_err == 0, "R4 single outstanding read", 32'(proto_err), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule